// File: doc/BRIEF.md
# Probe Control and Sticky-Status Register

This block is a small register for the front end of a JTAG debug probe. It drives the target's system reset and test reset lines, a switch that can cut target power, two indicator LEDs and the enable for adaptive (returned-clock) mode. Software changes these outputs through two write addresses. One address turns on every control bit written as 1. The other turns off every control bit written as 1. A single bit can therefore be changed in one bus write, with no read of the register first.

The same register also holds three event flags. Each flag records a condition from the target: reset seen asserted, the supply dropped, or the returned clock timed out. Each flag is handled by a two-state machine with the states `FLAG_ARMED` and `FLAG_CAUGHT`. A re-arm write moves the flag to `FLAG_ARMED`. The transition `ARMED->CAUGHT` happens on any event that arrives after that write, and the flag stays caught until the next re-arm. Software re-arms a flag, waits, and reads the register to learn whether the event happened in that window.

Bus writes are decoded into the operations `OP_IDLE`, `OP_SET` and `OP_CLR`. The reset-sense and power-dropout inputs are asynchronous and pass through a synchronizer before any flag sees them. The timeout input is a single-cycle pulse already in the clock domain of this block.

Top module: `probe_csr`

## Requirements
- R1: A write to the set address (default 0x10) turns on each control bit whose write-data bit is 1. The other control bits keep their values.
- R2: A write to the clear address (default 0x14) turns off each control bit whose write-data bit is 1. The other control bits keep their values.
- R3: The control bits map to the outputs as follows:
  - bit 0 drives `sys_rst_o` (1 = asserted);
  - bit 1 drives `test_rst_o` (1 = asserted);
  - bit 3 drives `pwr_off_o` (1 = power cut, 0 = power on);
  - bits 5:4 drive `led_o[1:0]`;
  - bit 8 drives `adapt_clk_o` (1 = adaptive clock, 0 = fixed divider).
  Write-data bits 2, 9 and 11 and above change nothing and always read 0. The outputs change only in response to a write.
- R4: `bus_rdata` is updated one cycle after a cycle in which `bus_rd` is high.
  - A read of the set address returns the control bits together with the flag bits 6, 7 and 10.
  - A read of any other address returns 0.
  - A write to any address other than the set and clear addresses has no effect.
- R5: Bit 6 latches when the synchronized reset-sense input is high. A write to the set address with bit 6 = 1 re-arms it. A write to the clear address with bit 6 = 1 has no effect on it. Once caught, it stays set after the input falls.
- R6: Bit 7 latches when the synchronized power-dropout input is high. A write to the set address with bit 7 = 1 re-arms it.
- R7: Bit 10 latches on a pulse of `rclk_timeout_i`. A write to the clear address with bit 10 = 1 clears it. A write to the set address with bit 10 = 1 has no effect on it.
- R8: A re-arm wins over an event in the same cycle, so the flag reads 0 afterwards. An event in any later cycle latches, including an input that is still high after the re-arm.
- R9: The reset-sense and power-dropout inputs pass through `SYNC_STAGES` flops (default 2) before a flag samples them. With the default, a one-cycle high input sampled at edge k sets the flag at edge k+2. A read issued in the cycle before edge k+3 then sees the flag.
- R10: In reset, every control output is deasserted, target power is on (`pwr_off_o` = 0), both LEDs are off, every flag is clear and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the strobe |
| tgt_rst_sense_i | input | 1 | Asynchronous target reset sense, 1 = asserted |
| tgt_pwr_drop_i | input | 1 | Asynchronous supply dropout indication |
| rclk_timeout_i | input | 1 | One-cycle pulse on a returned-clock timeout |
| sys_rst_o | output | 1 | Target system reset drive |
| test_rst_o | output | 1 | Target test reset drive |
| pwr_off_o | output | 1 | Target power cut, 1 = off |
| led_o | output | 2 | Indicator LEDs |
| adapt_clk_o | output | 1 | Adaptive clock mode enable |

## Verification
The bench builds the block with its default parameters:

| Parameter | Value |
|---|---|
| ADDR_W | 8 |
| DATA_W | 32 |
| SET_ADDR | 0x10 |
| CLR_ADDR | 0x14 |
| SYNC_STAGES | 2 |

The full 32-bit data word lets the bench write all-ones patterns, so the unused and upper bits are tried against both write addresses. The spare address 0x18 exercises the decode of writes and reads outside the map. With two synchronizer stages the bench can pin down the exact cycle in which a reset-sense event first becomes readable. It also drives a re-arm and an event into the same clock edge to check the priority between them.

// File: rtl/probe_csr_pkg.sv
`timescale 1ns/1ps
package probe_csr_pkg;

    localparam int REG_W     = 11;
    localparam int B_SYS_RST = 0;
    localparam int B_TST_RST = 1;
    localparam int B_PWR_OFF = 3;
    localparam int B_LED0    = 4;
    localparam int B_LED1    = 5;
    localparam int B_SENSE   = 6;
    localparam int B_DROP    = 7;
    localparam int B_ADAPT   = 8;
    localparam int B_TMO     = 10;

    // bits that are plain set/clear controls
    localparam logic [REG_W-1:0] CTRL_MASK = 11'h13B;

    localparam int N_FLAG  = 3;
    localparam int F_SENSE = 0;
    localparam int F_DROP  = 1;
    localparam int F_TMO   = 2;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_SET,
        OP_CLR
    } bus_op_e;

    typedef enum logic {
        FLAG_ARMED,
        FLAG_CAUGHT
    } flag_state_e;

endpackage

// File: rtl/probe_csr_sync.sv
`timescale 1ns/1ps
module probe_csr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/probe_csr_sticky.sv
`timescale 1ns/1ps
module probe_csr_sticky
    import probe_csr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rearm_i,
    input  logic event_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_ARMED;
        else     state_q <= state_d;
    end

    // re-arm wins over an event in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_ARMED:  if (event_i && !rearm_i) state_d = FLAG_CAUGHT;
            FLAG_CAUGHT: if (rearm_i)             state_d = FLAG_ARMED;
            default:     state_d = FLAG_ARMED;
        endcase
    end

    always_comb flag_o = (state_q == FLAG_CAUGHT);
endmodule

// File: rtl/probe_csr_ctrl.sv
`timescale 1ns/1ps
module probe_csr_ctrl
    import probe_csr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_e           op_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o
);
    localparam logic [DATA_W-1:0] MASK = DATA_W'(CTRL_MASK);

    logic [DATA_W-1:0] hit;
    assign hit = wdata_i & MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
        end else begin
            unique case (op_i)
                OP_SET:  ctrl_o <= ctrl_o | hit;
                OP_CLR:  ctrl_o <= ctrl_o & ~hit;
                default: ctrl_o <= ctrl_o;
            endcase
        end
    end
endmodule

// File: rtl/probe_csr.sv
`timescale 1ns/1ps
module probe_csr
    import probe_csr_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] SET_ADDR    = 8'h10,
    parameter logic [ADDR_W-1:0] CLR_ADDR    = 8'h14,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tgt_rst_sense_i,
    input  logic              tgt_pwr_drop_i,
    input  logic              rclk_timeout_i,
    output logic              sys_rst_o,
    output logic              test_rst_o,
    output logic              pwr_off_o,
    output logic [1:0]        led_o,
    output logic              adapt_clk_o
);
    bus_op_e           op;
    logic [DATA_W-1:0] ctrl_q;
    logic [1:0]        synced;
    logic [N_FLAG-1:0] rearm;
    logic [N_FLAG-1:0] evt;
    logic [N_FLAG-1:0] flag_q;
    logic [DATA_W-1:0] status;

    always_comb begin
        op = OP_IDLE;
        if (bus_wr && bus_addr == SET_ADDR)      op = OP_SET;
        else if (bus_wr && bus_addr == CLR_ADDR) op = OP_CLR;
    end

    probe_csr_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .wdata_i (bus_wdata),
        .ctrl_o  (ctrl_q)
    );

    probe_csr_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i ({tgt_pwr_drop_i, tgt_rst_sense_i}),
        .q_o (synced)
    );

    always_comb begin
        rearm[F_SENSE] = (op == OP_SET) && bus_wdata[B_SENSE];
        rearm[F_DROP]  = (op == OP_SET) && bus_wdata[B_DROP];
        rearm[F_TMO]   = (op == OP_CLR) && bus_wdata[B_TMO];
        evt[F_SENSE]   = synced[0];
        evt[F_DROP]    = synced[1];
        evt[F_TMO]     = rclk_timeout_i;
    end

    generate
        for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
            probe_csr_sticky flag_i (
                .clk     (clk),
                .rst     (rst),
                .rearm_i (rearm[g]),
                .event_i (evt[g]),
                .flag_o  (flag_q[g])
            );
        end
    endgenerate

    always_comb begin
        status          = ctrl_q;
        status[B_SENSE] = flag_q[F_SENSE];
        status[B_DROP]  = flag_q[F_DROP];
        status[B_TMO]   = flag_q[F_TMO];
    end

    always_ff @(posedge clk) begin
        if (rst)                                bus_rdata <= '0;
        else if (bus_rd && bus_addr == SET_ADDR) bus_rdata <= status;
        else                                    bus_rdata <= '0;
    end

    assign sys_rst_o   = ctrl_q[B_SYS_RST];
    assign test_rst_o  = ctrl_q[B_TST_RST];
    assign pwr_off_o   = ctrl_q[B_PWR_OFF];
    assign led_o       = {ctrl_q[B_LED1], ctrl_q[B_LED0]};
    assign adapt_clk_o = ctrl_q[B_ADAPT];
endmodule

// File: rtl/probe_csr_chk.sv
`timescale 1ns/1ps
module probe_csr_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SET_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h14
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              w0,
    input logic              w6,
    input logic              w7,
    input logic              w10,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              sense_raw,
    input logic              tmo_pulse,
    input logic              sys_rst_o,
    input logic              test_rst_o,
    input logic              pwr_off_o,
    input logic [1:0]        led_o,
    input logic              adapt_clk_o,
    input logic [2:0]        flag_vec
);
    logic wr_set, wr_clr;
    assign wr_set = bus_wr && bus_addr == SET_ADDR;
    assign wr_clr = bus_wr && bus_addr == CLR_ADDR;

    // R1
    set_bit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_set && w0 |=> sys_rst_o);

    // R2
    clr_bit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clr && w0 |=> !sys_rst_o);

    // R3
    outs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable({sys_rst_o, test_rst_o, pwr_off_o, led_o, adapt_clk_o}));

    // R4
    other_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_addr != SET_ADDR |=> bus_rdata == '0);

    // R5
    sense_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        wr_set && w6 |=> !flag_vec[0]);

    // R6
    drop_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        wr_set && w7 |=> !flag_vec[1]);

    // R7
    tmo_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clr && w10 |=> !flag_vec[2]);

    // R8
    tmo_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_vec[2]) |-> $past(tmo_pulse) && !$past(wr_clr && w10));

    // R9
    sense_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_vec[0]) |-> $past(sense_raw, 3));
endmodule

bind probe_csr probe_csr_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SET_ADDR (SET_ADDR),
    .CLR_ADDR (CLR_ADDR)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .w0          (bus_wdata[0]),
    .w6          (bus_wdata[6]),
    .w7          (bus_wdata[7]),
    .w10         (bus_wdata[10]),
    .bus_rdata   (bus_rdata),
    .sense_raw   (tgt_rst_sense_i),
    .tmo_pulse   (rclk_timeout_i),
    .sys_rst_o   (sys_rst_o),
    .test_rst_o  (test_rst_o),
    .pwr_off_o   (pwr_off_o),
    .led_o       (led_o),
    .adapt_clk_o (adapt_clk_o),
    .flag_vec    (flag_q)
);

// File: tb/probe_csr_tb_top.sv
`timescale 1ns/1ps
module probe_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        sense = 1'b0;
    logic        drop = 1'b0;
    logic        tmo = 1'b0;
    logic        sys_rst_o, test_rst_o, pwr_off_o, adapt_clk_o;
    logic [1:0]  led_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    probe_csr dut_i (
        .clk             (clk),
        .rst             (rst),
        .bus_addr        (bus_addr),
        .bus_wr          (bus_wr),
        .bus_wdata       (bus_wdata),
        .bus_rd          (bus_rd),
        .bus_rdata       (bus_rdata),
        .tgt_rst_sense_i (sense),
        .tgt_pwr_drop_i  (drop),
        .rclk_timeout_i  (tmo),
        .sys_rst_o       (sys_rst_o),
        .test_rst_o      (test_rst_o),
        .pwr_off_o       (pwr_off_o),
        .led_o           (led_o),
        .adapt_clk_o     (adapt_clk_o)
    );

    // {address, write data, expected readback of the set address}
    localparam int NV = 11;
    localparam logic [71:0] VEC [NV] = '{
        {8'h10, 32'h0000_0030, 32'h0000_0030},
        {8'h10, 32'h0000_0001, 32'h0000_0031},
        {8'h10, 32'h0000_0002, 32'h0000_0033},
        {8'h14, 32'h0000_0001, 32'h0000_0032},
        {8'h10, 32'h0000_0108, 32'h0000_013A},
        {8'h14, 32'h0000_0100, 32'h0000_003A},
        {8'h10, 32'h0000_0204, 32'h0000_003A},
        {8'h18, 32'hFFFF_FFFF, 32'h0000_003A},
        {8'h14, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h10, 32'hFFFF_FFFF, 32'h0000_013B},
        {8'h14, 32'h0000_013B, 32'h0000_0000}
    };

    function automatic logic [31:0] outs();
        return {23'b0, adapt_clk_o, 2'b00, led_o, pwr_off_o, 1'b0, test_rst_o, sys_rst_o};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] got;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset values
        check("R10 outputs in reset", outs(), 32'h0);
        check("R10 rdata in reset", bus_rdata, 32'h0);
        @(negedge clk); rst = 1'b0;
        bus_read(8'h10, got);
        check("R10 readback after reset", got, 32'h0);

        // R1 R2 R3 R4 table walk
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][71:64], VEC[i][63:32]);
            bus_read(8'h10, got);
            check($sformatf("R1/R2/R3/R4 vector %0d readback", i), got, VEC[i][31:0]);
            check($sformatf("R3 vector %0d outputs", i), outs(), VEC[i][31:0] & 32'h13B);
        end
        bus_write(8'h10, 32'h0000_0030);
        bus_read(8'h18, got);
        check("R4 other address reads zero", got, 32'h0);
        bus_write(8'h14, 32'h0000_0030);

        // R9 exact latency: raw high before edge E0, continuous reads
        @(negedge clk);
        sense = 1'b1; bus_addr = 8'h10; bus_rd = 1'b1;
        @(posedge clk); #1;
        sense = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R9 flag not yet visible", bus_rdata & 32'h40, 32'h0);
        @(posedge clk); #1;
        check("R9 flag visible third edge on", bus_rdata & 32'h40, 32'h40);
        bus_rd = 1'b0;

        // R5 persistence and clear-address immunity, then re-arm
        idle(3);
        bus_read(8'h10, got);
        check("R5 flag stays after input falls", got, 32'h40);
        bus_write(8'h14, 32'h0000_0040);
        bus_read(8'h10, got);
        check("R5 clear address leaves flag", got, 32'h40);
        bus_write(8'h10, 32'h0000_0040);
        bus_read(8'h10, got);
        check("R5 set address re-arms", got, 32'h0);

        // R8 input still high across re-arm latches again
        @(negedge clk); sense = 1'b1;
        idle(4);
        bus_write(8'h10, 32'h0000_0040);
        idle(2);
        bus_read(8'h10, got);
        check("R8 event after re-arm latches", got, 32'h40);
        @(negedge clk); sense = 1'b0;
        idle(4);
        bus_write(8'h10, 32'h0000_0040);
        bus_read(8'h10, got);
        check("R5 re-arm after input low", got, 32'h0);

        // R6 dropout
        @(negedge clk); drop = 1'b1;
        @(posedge clk); #1; drop = 1'b0;
        idle(4);
        bus_read(8'h10, got);
        check("R6 dropout latched", got, 32'h80);
        bus_write(8'h10, 32'h0000_0080);
        bus_read(8'h10, got);
        check("R6 dropout re-armed", got, 32'h0);

        // R7 timeout
        @(negedge clk); tmo = 1'b1;
        @(posedge clk); #1; tmo = 1'b0;
        bus_read(8'h10, got);
        check("R7 timeout latched", got, 32'h400);
        bus_write(8'h10, 32'h0000_0400);
        bus_read(8'h10, got);
        check("R7 set address leaves timeout", got, 32'h400);
        check("R7 set of bit 10 leaves outputs", outs(), 32'h0);
        bus_write(8'h14, 32'h0000_0400);
        bus_read(8'h10, got);
        check("R7 clear address clears timeout", got, 32'h0);

        // R8 same-cycle clear and pulse: clear wins
        @(negedge clk); tmo = 1'b1;
        @(posedge clk); #1; tmo = 1'b0;
        @(negedge clk);
        bus_addr = 8'h14; bus_wdata = 32'h400; bus_wr = 1'b1; tmo = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0; tmo = 1'b0;
        bus_read(8'h10, got);
        check("R8 re-arm wins same cycle", got, 32'h0);
        @(negedge clk); tmo = 1'b1;
        @(posedge clk); #1; tmo = 1'b0;
        bus_read(8'h10, got);
        check("R8 later pulse latches", got, 32'h400);

        // R10 reset in mid run
        bus_write(8'h10, 32'h0000_013B);
        check("R1 all controls on", outs(), 32'h13B);
        @(negedge clk); rst = 1'b1;
        idle(2);
        check("R10 outputs after reset", outs(), 32'h0);
        @(negedge clk); rst = 1'b0;
        bus_read(8'h10, got);
        check("R10 flags cleared by reset", got, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule